// File: doc/BRIEF.md
# Control-Word Steered Register Datapath

This block is the register-transfer core of a small processor. A 16-bit control word, applied for one clock cycle, decides everything the datapath does in that cycle: which register drives the A operand bus, whether the B operand bus carries a register or an external constant, which operation code goes to the function unit, whether the value written back comes from the function unit or from external data, and whether any register is written at all. One microoperation completes in each clock cycle.

The arithmetic, logic and shift work is done by a function unit outside this block. The core hands that unit the two operand buses and the 4-bit operation code. It takes back the result and the overflow, carry, negative and zero flags, and presents those flags on its own outputs. The A bus also serves as the memory address output and the B bus as the memory data output. A memory or port write therefore needs only a control word whose register-write bit is cleared. The register file holds eight registers of `DW` bits each.

Top module: `cwdp_core`

## Requirements
- R1: The control word fields sit at fixed positions: destination register in bits 15:13, A-bus register in bits 12:10, B-read register in bits 9:7, B-bus source in bit 6, operation code in bits 5:2, write-back source in bit 1 and register write enable in bit 0. Each 3-bit register code n selects register n directly.
- R2: `addr_out` (the A bus) shows, in the same cycle and combinationally, the register selected by bits 12:10. The function unit receives the A bus as its first operand.
- R3: When bit 6 is 0, `data_out` (the B bus) shows the register selected by bits 9:7. When bit 6 is 1, it shows `const_in`.
- R4: When bit 1 is 0, the write-back value is `fu_result`. When bit 1 is 1, it is `data_in`.
- R5: When bit 0 is 1, the register selected by bits 15:13 takes the write-back value on the rising clock edge. When bit 0 is 0, no register changes, whatever the other fields hold.
- R6: A register that is read and written in the same cycle shows its old value until the edge.
- R7: A synchronous active-high `rst` clears all eight registers to zero.
- R8: `fu_op` carries bits 5:2 unchanged. `flag_v`, `flag_c`, `flag_n` and `flag_z` show the function unit flags of the current cycle combinationally.
- R9: Back-to-back microoperations chain: a value written at one edge is visible on both read ports in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the register file |
| ctl_word | input | 16 | Control word for the current cycle |
| const_in | input | DW | External constant for the B bus |
| data_in | input | DW | External data for write-back |
| fu_result | input | DW | Result from the external function unit |
| fu_v | input | 1 | Overflow flag from the function unit |
| fu_c | input | 1 | Carry flag from the function unit |
| fu_n | input | 1 | Negative flag from the function unit |
| fu_z | input | 1 | Zero flag from the function unit |
| fu_op | output | 4 | Operation code sent to the function unit |
| addr_out | output | DW | A bus: address output and first function unit operand |
| data_out | output | DW | B bus: data output and second function unit operand |
| flag_v | output | 1 | Overflow status |
| flag_c | output | 1 | Carry status |
| flag_n | output | 1 | Negative status |
| flag_z | output | 1 | Zero status |

## Verification
The assertions assume that the control word, `const_in`, `data_in` and the function unit inputs are stable and known around each rising edge. They also assume that the function unit result depends only on the operand buses and the operation code of the same cycle. The bench drives every input at the falling edge and models the function unit as a combinational process fed from the design's own operand outputs, so both assumptions hold. Reset is raised only at a falling edge and held across at least one rising edge.

// File: rtl/cwdp_pkg.sv
package cwdp_pkg;

    localparam int CW_W   = 16;
    localparam int RSEL_W = 3;
    localparam int OP_W   = 4;

    // Packed so that the first member occupies the top bits of the word.
    typedef struct packed {
        logic [RSEL_W-1:0] dst;    // 15:13
        logic [RSEL_W-1:0] rsa;    // 12:10
        logic [RSEL_W-1:0] rsb;    // 9:7
        logic              b_ext;  // 6
        logic [OP_W-1:0]   op;     // 5:2
        logic              d_ext;  // 1
        logic              wen;    // 0
    } ctl_t;

endpackage

// File: rtl/cwdp_decode.sv
module cwdp_decode
    import cwdp_pkg::*;
(
    input  logic [CW_W-1:0]   word_i,
    output logic [RSEL_W-1:0] dst_o,
    output logic [RSEL_W-1:0] rsa_o,
    output logic [RSEL_W-1:0] rsb_o,
    output logic              b_ext_o,
    output logic [OP_W-1:0]   op_o,
    output logic              d_ext_o,
    output logic              wen_o
);

    ctl_t fields;

    always_comb begin
        fields  = ctl_t'(word_i);
        dst_o   = fields.dst;
        rsa_o   = fields.rsa;
        rsb_o   = fields.rsb;
        b_ext_o = fields.b_ext;
        op_o    = fields.op;
        d_ext_o = fields.d_ext;
        wen_o   = fields.wen;
    end

    always_comb begin
        AST_FIELD_WIDTH: assert ($bits(ctl_t) == CW_W); // R1
    end

endmodule

// File: rtl/cwdp_sel2.sv
module cwdp_sel2 #(
    parameter int DW = 8
) (
    input  logic          pick_i,
    input  logic [DW-1:0] in0_i,
    input  logic [DW-1:0] in1_i,
    output logic [DW-1:0] out_o
);

    always_comb begin
        out_o = pick_i ? in1_i : in0_i;
    end

endmodule

// File: rtl/cwdp_regfile.sv
module cwdp_regfile #(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_a_i,
    input  logic [AW-1:0] raddr_b_i,
    output logic [DW-1:0] rdata_a_o,
    output logic [DW-1:0] rdata_b_o
);

    localparam int NREG = 1 << AW;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.regs = '0;
        end else if (we_i) begin
            st_d.regs[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    // Read ports show the stored value: a same-cycle write is seen after the edge.
    always_comb begin
        rdata_a_o = st_q.regs[raddr_a_i];
        rdata_b_o = st_q.regs[raddr_b_i];
    end

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> (st_q.regs == '0)); // R7

    AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (rst_i)
        we_i |=> (st_q.regs[$past(waddr_i)] == $past(wdata_i))); // R5

    AST_NO_WRITE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !we_i |=> $stable(st_q.regs)); // R5

    for (genvar gi = 0; gi < NREG; gi++) begin : g_hold
        AST_OTHERS_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
            (we_i && (waddr_i != AW'(gi))) |=> $stable(st_q.regs[gi])); // R5
    end

endmodule

// File: rtl/cwdp_core.sv
module cwdp_core
    import cwdp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CW_W-1:0] ctl_word,
    input  logic [DW-1:0]   const_in,
    input  logic [DW-1:0]   data_in,
    input  logic [DW-1:0]   fu_result,
    input  logic            fu_v,
    input  logic            fu_c,
    input  logic            fu_n,
    input  logic            fu_z,
    output logic [OP_W-1:0] fu_op,
    output logic [DW-1:0]   addr_out,
    output logic [DW-1:0]   data_out,
    output logic            flag_v,
    output logic            flag_c,
    output logic            flag_n,
    output logic            flag_z
);

    logic [RSEL_W-1:0] dst_s, rsa_s, rsb_s;
    logic              b_ext_s, d_ext_s, wen_s;
    logic [OP_W-1:0]   op_s;
    logic [DW-1:0]     rd_a_s, rd_b_s, bus_b_s, bus_d_s;

    cwdp_decode u_decode (
        .word_i  (ctl_word),
        .dst_o   (dst_s),
        .rsa_o   (rsa_s),
        .rsb_o   (rsb_s),
        .b_ext_o (b_ext_s),
        .op_o    (op_s),
        .d_ext_o (d_ext_s),
        .wen_o   (wen_s)
    );

    cwdp_regfile #(.DW(DW), .AW(RSEL_W)) u_rf (
        .clk_i     (clk),
        .rst_i     (rst),
        .we_i      (wen_s),
        .waddr_i   (dst_s),
        .wdata_i   (bus_d_s),
        .raddr_a_i (rsa_s),
        .raddr_b_i (rsb_s),
        .rdata_a_o (rd_a_s),
        .rdata_b_o (rd_b_s)
    );

    cwdp_sel2 #(.DW(DW)) u_mux_b (
        .pick_i (b_ext_s),
        .in0_i  (rd_b_s),
        .in1_i  (const_in),
        .out_o  (bus_b_s)
    );

    cwdp_sel2 #(.DW(DW)) u_mux_d (
        .pick_i (d_ext_s),
        .in0_i  (fu_result),
        .in1_i  (data_in),
        .out_o  (bus_d_s)
    );

    always_comb begin
        addr_out = rd_a_s;
        data_out = bus_b_s;
        fu_op    = op_s;
        flag_v   = fu_v;
        flag_c   = fu_c;
        flag_n   = fu_n;
        flag_z   = fu_z;
    end

    AST_BUS_B_CONST: assert property (@(posedge clk) disable iff (rst)
        ctl_word[6] |-> (data_out == const_in)); // R3

    AST_BUS_D_EXT: assert property (@(posedge clk) disable iff (rst)
        ctl_word[1] |-> (bus_d_s == data_in)); // R4

    AST_BUS_D_FU: assert property (@(posedge clk) disable iff (rst)
        !ctl_word[1] |-> (bus_d_s == fu_result)); // R4

    AST_OP_FIELD: assert property (@(posedge clk) disable iff (rst)
        fu_op == ctl_word[5:2]); // R8

endmodule

// File: tb/cwdp_core_tb_top.sv
module cwdp_core_tb_top;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [15:0]   ctl_word;
    logic [DW-1:0] const_in, data_in, fu_result;
    logic          fu_v, fu_c, fu_n, fu_z;
    logic [3:0]    fu_op;
    logic [DW-1:0] addr_out, data_out;
    logic          flag_v, flag_c, flag_n, flag_z;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    cwdp_core #(.DW(DW)) dut_i (
        .clk(clk), .rst(rst), .ctl_word(ctl_word),
        .const_in(const_in), .data_in(data_in), .fu_result(fu_result),
        .fu_v(fu_v), .fu_c(fu_c), .fu_n(fu_n), .fu_z(fu_z),
        .fu_op(fu_op), .addr_out(addr_out), .data_out(data_out),
        .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
    );

    // Function unit model fed from the design's operand buses.
    always_comb begin
        logic [DW:0] s;
        s = '0;
        case (fu_op)
            4'd0:  s = {1'b0, addr_out};
            4'd1:  s = {1'b0, addr_out} + 1'b1;
            4'd2:  s = {1'b0, addr_out} + {1'b0, data_out};
            4'd3:  s = {1'b0, addr_out} + {1'b0, data_out} + 1'b1;
            4'd5:  s = {1'b0, addr_out} + {1'b0, ~data_out} + 1'b1;
            4'd8:  s = {1'b0, addr_out & data_out};
            4'd10: s = {1'b0, addr_out ^ data_out};
            4'd14: s = {1'b0, data_out[DW-2:0], 1'b0};
            default: s = {1'b0, data_out};
        endcase
        fu_result = s[DW-1:0];
        fu_c = s[DW];
        fu_n = s[DW-1];
        fu_z = (s[DW-1:0] == '0);
        fu_v = (fu_op == 4'd2 || fu_op == 4'd3) &&
               (addr_out[DW-1] == data_out[DW-1]) && (s[DW-1] != addr_out[DW-1]);
    end

    function automatic logic [15:0] cw(input int da, input int aa, input int ba,
                                       input bit mb, input int fs, input bit md,
                                       input bit rw);
        // R1: dst 15:13, A 12:10, B 9:7, B source 6, op 5:2, D source 1, write 0
        return {3'(da), 3'(aa), 3'(ba), mb, 4'(fs), md, rw};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply a control word at the falling edge.
    task automatic apply(input logic [15:0] w);
        @(negedge clk);
        ctl_word = w;
    endtask

    task automatic read_reg(input int r, output logic [DW-1:0] v);
        apply(cw(0, r, 0, 0, 0, 0, 0));
        #1 v = addr_out;
    endtask

    task automatic t_reset;
        logic [DW-1:0] v;
        for (int r = 0; r < 8; r++) begin
            read_reg(r, v);
            check("R7 reset clears", v, 0);
        end
    endtask

    task automatic t_load;
        logic [DW-1:0] v;
        for (int r = 0; r < 8; r++) begin
            apply(cw(r, 0, 0, 0, 0, 1, 1));
            data_in = 8'h11 * (r + 1);
        end
        for (int r = 0; r < 8; r++) begin
            read_reg(r, v);
            check("R4 R5 R1 data in load", v, 8'h11 * (r + 1));
        end
    endtask

    task automatic t_buses;
        apply(cw(0, 3, 6, 0, 0, 0, 0));
        const_in = 8'hA5;
        #1;
        check("R2 bus A", addr_out, 8'h44);
        check("R3 bus B register", data_out, 8'h77);
        apply(cw(0, 3, 6, 1, 0, 0, 0));
        #1 check("R3 bus B constant", data_out, 8'hA5);
    endtask

    task automatic t_add;
        logic [DW-1:0] v;
        // R1 <= R2 + R3 + 1 = 0x33 + 0x44 + 1
        apply(cw(1, 2, 3, 0, 3, 0, 1));
        #1;
        check("R8 op field", fu_op, 3);
        check("R8 flag n", flag_n, 1'b0);
        check("R8 flag z", flag_z, 1'b0);
        read_reg(1, v);
        check("R4 function result write", v, 8'h78);
        // R5 <= R0 xor R0 (zero), check flags of current op
        apply(cw(5, 0, 0, 0, 10, 0, 1));
        #1 check("R8 flag z set", flag_z, 1'b1);
        read_reg(5, v);
        check("R4 zero result", v, 0);
        // R6 <= R7 + 0x90 (0x88+0x90 carries)
        apply(cw(6, 7, 0, 1, 2, 0, 1));
        const_in = 8'h90;
        #1;
        check("R8 flag c", flag_c, 1'b1);
        check("R8 flag v", flag_v, 1'b1);
        read_reg(6, v);
        check("R3 R4 constant add", v, 8'h18);
    endtask

    task automatic t_nowrite;
        logic [DW-1:0] v;
        apply(cw(4, 4, 4, 1, 2, 1, 0));
        data_in = 8'hEE;
        const_in = 8'h01;
        apply(cw(2, 4, 4, 0, 14, 0, 0));
        read_reg(4, v);
        check("R5 no write keeps R4", v, 8'h55);
        read_reg(2, v);
        check("R5 no write keeps R2", v, 8'h33);
    endtask

    task automatic t_rdw;
        logic [DW-1:0] v;
        apply(cw(2, 2, 2, 0, 1, 0, 1));
        #1;
        check("R6 old value before edge", addr_out, 8'h33);
        @(posedge clk);
        #1 check("R6 new value after edge", addr_out, 8'h34);
        read_reg(2, v);
        check("R6 stored", v, 8'h34);
    endtask

    task automatic t_chain;
        logic [DW-1:0] v;
        for (int k = 0; k < 3; k++) apply(cw(7, 7, 0, 0, 1, 0, 1));
        apply(cw(0, 7, 7, 0, 0, 0, 0));
        #1;
        check("R9 chained A", addr_out, 8'h8B);
        check("R9 chained B", data_out, 8'h8B);
        read_reg(7, v);
        check("R9 chained store", v, 8'h8B);
    endtask

    task automatic t_mid_reset;
        logic [DW-1:0] v;
        apply(cw(3, 0, 0, 0, 0, 1, 1));
        data_in = 8'hFF;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ctl_word = cw(0, 0, 0, 0, 0, 0, 0);
        for (int r = 0; r < 8; r++) begin
            read_reg(r, v);
            check("R7 reset over write", v, 0);
        end
    endtask

    initial begin
        #190000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        ctl_word = '0;
        const_in = '0;
        data_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load();
        t_buses();
        t_add();
        t_nowrite();
        t_rdw();
        t_chain();
        t_mid_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule